// File: doc/BRIEF.md
# Two-Level Translation Cache

This block caches virtual-to-physical translations for 32-bit addresses. A requester presents a virtual address together with its security state. The block answers with hit or miss, the physical address and the page size. Small fully associative first-level storage answers most requests. Behind it sits a unified second level. That second level is a 2-way set-associative array of 4 KB translations plus a handful of fully associative slots that pin translations in place.

On a miss in both levels, an external table walker resolves the address and writes the result through the fill port. Software maintenance uses the two invalidation inputs: one drops everything that is not pinned, and the other drops the translations that cover one address. Issue lookups, fills and invalidations one at a time. Issue none of them in the cycle after a lookup that reached the second level, because that cycle writes the first level.

Top module: `tlb_two_level`

## Requirements
- R1: A lookup that hits the first level returns `rsp_valid`=1 and `rsp_hit`=1, with the physical address and size, on the clock edge after the request.
- R2: A lookup that misses the first level but hits the second level responds two edges after the request, with no response on the first edge. That translation is copied into the first level, so repeating the lookup is answered in one cycle.
- R3: A lookup that misses both levels returns `rsp_valid`=1, `rsp_hit`=0 and `rsp_pa`=0 one edge after the request. No response appears without a request.
- R4: The size code is 0 for 4 KB, 1 for 1 MB and 2 for 16 MB. The physical address takes its bits above 12, 20 or 24 from the stored frame number and the rest from the virtual address. Virtual addresses anywhere inside the page hit, and addresses outside it miss.
- R5: A translation hits only when the requester's `lk_ns` equals the `fill_ns` it was written with. Two translations for the same address in the two security states coexist.
- R6: Unpinned 4 KB fills go to the set selected by the virtual address bits directly above bit 12. An empty way is used first, otherwise the least recently used one. A second-level hit makes its way the most recently used.
- R7: Unpinned 1 MB and 16 MB fills are written straight into the first level and are answered in one cycle.
- R8: A fill with `fill_lock`=1 takes a free pinned slot. Pinned translations survive any number of conflicting fills. When all pinned slots are taken, a locked fill is treated as an unpinned fill.
- R9: `inv_all` clears every translation except pinned ones. With `unlock_all` also high, it clears pinned ones as well.
- R10: `inv_addr_valid` clears, in one cycle and in both levels, every translation whose page contains `inv_vpn`, in either security state. Other translations stay.
- R11: The first level replaces entries in round-robin order. After reset, filling one more large page than it holds evicts the first one written.
- R12: Reset empties both levels and holds `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_ns | input | 1 | Requester security state (1 = non-secure) |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | 20 | Virtual address bits 31:12 of the fill |
| fill_pfn | input | 20 | Physical address bits 31:12 of the fill |
| fill_ns | input | 1 | Security state stored with the fill |
| fill_size | input | 2 | Page size code of the fill |
| fill_lock | input | 1 | Request to pin the fill |
| inv_all | input | 1 | Invalidate all unpinned translations |
| unlock_all | input | 1 | With inv_all, also drop pinned translations |
| inv_addr_valid | input | 1 | Invalidate by address |
| inv_vpn | input | 20 | Virtual address bits 31:12 to invalidate |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 32 | Physical address |
| rsp_size | output | 2 | Page size code of the hit |

## Verification
A corrupted valid bit, tag or security flag shows up at the next lookup of the affected page. That lookup gets a wrong hit/miss answer or a wrong address within two cycles of the request. A fault in the way the levels cooperate shows up as a wrong latency instead. Examples are a missing copy into the first level, a wrong victim way, or a round-robin pointer that skips. A repeated lookup then takes two cycles where one was due, or misses where it should hit. The bench therefore predicts both the value and the cycle of every response, and flags any response that appears without a request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_1M  = 2'd1,
    PG_16M = 2'd2
  } pg_size_e;

  typedef struct packed {
    logic        ns;
    pg_size_e    size;
    logic [19:0] vpn;
    logic [19:0] pfn;
  } xlat_t;

  // bits of the 4 KB page number that belong to the page tag
  function automatic logic [19:0] pg_mask(input pg_size_e s);
    case (s)
      PG_4K:   return 20'hFFFFF;
      PG_1M:   return 20'hFFF00;
      default: return 20'hFF000;
    endcase
  endfunction

  function automatic logic xlat_cover(input xlat_t e, input logic [19:0] vpn);
    return ((e.vpn ^ vpn) & pg_mask(e.size)) == 20'd0;
  endfunction

  function automatic logic xlat_hit(input xlat_t e, input logic [19:0] vpn, input logic ns);
    return (e.ns == ns) && xlat_cover(e, vpn);
  endfunction

  function automatic logic [31:0] xlat_pa(input xlat_t e, input logic [31:0] va);
    logic [19:0] m;
    m = pg_mask(e.size);
    return {(e.pfn & m) | (va[31:12] & ~m), va[11:0]};
  endfunction

endpackage

// File: rtl/tlb_micro.sv
module tlb_micro import tlb_pkg::*; #(
  parameter int N = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [19:0] lk_vpn,
  input  logic        lk_ns,
  input  logic        wr_en,
  input  xlat_t       wr_data,
  input  logic        inv_all,
  input  logic        inv_addr,
  input  logic [19:0] inv_vpn,
  output logic        hit,
  output xlat_t       hit_data
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  vld, vld_nx;
  xlat_t         ent [N];
  logic [IW-1:0] rr;

  // lowest matching index wins
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && xlat_hit(ent[i], lk_vpn, lk_ns)) begin
        hit      = 1'b1;
        hit_data = ent[i];
      end
    end
  end

  always_comb begin
    vld_nx = vld;
    if (inv_all) begin
      vld_nx = '0;
    end else begin
      if (inv_addr) begin
        for (int i = 0; i < N; i++) begin
          if (xlat_cover(ent[i], inv_vpn)) vld_nx[i] = 1'b0;
        end
      end
      if (wr_en) vld_nx[rr] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      vld <= vld_nx;
      if (wr_en && !inv_all) rr <= (rr == IW'(N - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) ent[rr] <= wr_data;
  end

endmodule

// File: rtl/tlb_lock.sv
module tlb_lock import tlb_pkg::*; #(
  parameter int N = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [19:0] lk_vpn,
  input  logic        lk_ns,
  input  logic        wr_en,
  input  xlat_t       wr_data,
  input  logic        inv_all,
  input  logic        unlock_all,
  input  logic        inv_addr,
  input  logic [19:0] inv_vpn,
  output logic        hit,
  output xlat_t       hit_data,
  output logic        full
);
  logic [N-1:0] vld, vld_nx, free_sel;
  logic         found;
  xlat_t        ent [N];

  assign full = &vld;

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && xlat_hit(ent[i], lk_vpn, lk_ns)) begin
        hit      = 1'b1;
        hit_data = ent[i];
      end
    end
  end

  always_comb begin
    free_sel = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!vld[i] && !found) begin
        free_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    vld_nx = vld;
    if (inv_all) begin
      if (unlock_all) vld_nx = '0;
    end else begin
      if (inv_addr) begin
        for (int i = 0; i < N; i++) begin
          if (xlat_cover(ent[i], inv_vpn)) vld_nx[i] = 1'b0;
        end
      end
      if (wr_en && !full) vld_nx = vld_nx | free_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= vld_nx;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_en && !full && !inv_all && free_sel[i]) ent[i] <= wr_data;
    end
  end

  AST_LOCK_TAKES_SLOT: assert property (@(posedge clk) disable iff (rst)
    wr_en && !full && !inv_all && !inv_addr |=> $countones(vld) == $countones($past(vld)) + 1); // R8
  AST_LOCK_KEPT_ON_FLUSH: assert property (@(posedge clk) disable iff (rst)
    inv_all && !unlock_all && !inv_addr |=> vld == $past(vld)); // R9
  AST_UNLOCK_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    inv_all && unlock_all |=> vld == '0); // R9

endmodule

// File: rtl/tlb_main_array.sv
module tlb_main_array import tlb_pkg::*; #(
  parameter int SETS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lk_en,
  input  logic [19:0] lk_vpn,
  input  logic        lk_ns,
  input  logic        wr_en,
  input  xlat_t       wr_data,
  input  logic        inv_all,
  input  logic        inv_addr,
  input  logic [19:0] inv_vpn,
  output logic        hit,
  output xlat_t       hit_data
);
  localparam int SW = $clog2(SETS);

  logic [SETS-1:0] v0, v1, lru;   // lru=1: way 1 is least recently used
  xlat_t           w0 [SETS];
  xlat_t           w1 [SETS];
  logic [SW-1:0]   lset, fset, iset;
  logic            h0, h1, victim;

  assign lset = lk_vpn[SW-1:0];
  assign fset = wr_data.vpn[SW-1:0];
  assign iset = inv_vpn[SW-1:0];

  assign h0       = v0[lset] && xlat_hit(w0[lset], lk_vpn, lk_ns);
  assign h1       = v1[lset] && xlat_hit(w1[lset], lk_vpn, lk_ns);
  assign hit      = h0 | h1;
  assign hit_data = h0 ? w0[lset] : w1[lset];
  assign victim   = !v0[fset] ? 1'b0 : (!v1[fset] ? 1'b1 : lru[fset]);

  always_ff @(posedge clk) begin
    if (rst) begin
      v0  <= '0;
      v1  <= '0;
      lru <= '0;
    end else if (inv_all) begin
      v0 <= '0;
      v1 <= '0;
    end else begin
      if (inv_addr) begin
        if (xlat_cover(w0[iset], inv_vpn)) v0[iset] <= 1'b0;
        if (xlat_cover(w1[iset], inv_vpn)) v1[iset] <= 1'b0;
      end
      if (wr_en) begin
        if (victim) v1[fset] <= 1'b1;
        else        v0[fset] <= 1'b1;
        lru[fset] <= ~victim;
      end else if (lk_en && hit) begin
        lru[lset] <= h0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) begin
      if (victim) w1[fset] <= wr_data;
      else        w0[fset] <= wr_data;
    end
  end

endmodule

// File: rtl/tlb_two_level.sv
module tlb_two_level import tlb_pkg::*; #(
  parameter int UT_N      = 32,
  parameter int MAIN_SETS = 32,
  parameter int LOCK_N    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lk_valid,
  input  logic [31:0] lk_va,
  input  logic        lk_ns,
  input  logic        fill_valid,
  input  logic [19:0] fill_vpn,
  input  logic [19:0] fill_pfn,
  input  logic        fill_ns,
  input  logic [1:0]  fill_size,
  input  logic        fill_lock,
  input  logic        inv_all,
  input  logic        unlock_all,
  input  logic        inv_addr_valid,
  input  logic [19:0] inv_vpn,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_size
);
  xlat_t       fill_x, u_data, l_data, a_data, m_data, pend_x, u_wdata;
  logic        u_hit, l_hit, a_hit, l_full, m_hit;
  logic        to_lock, to_arr, to_u, u_wr, lk_go, inv_any, pend_q;
  logic [31:0] pend_va;

  assign fill_x  = '{ns: fill_ns, size: pg_size_e'(fill_size), vpn: fill_vpn, pfn: fill_pfn};
  assign inv_any = inv_all | inv_addr_valid;
  assign lk_go   = lk_valid && !pend_q;
  assign to_lock = fill_valid && fill_lock && !l_full;
  assign to_arr  = fill_valid && !to_lock && (fill_size == 2'd0);
  assign to_u    = fill_valid && !to_lock && (fill_size != 2'd0);
  assign u_wr    = to_u || (pend_q && !inv_any);
  assign u_wdata = pend_q ? pend_x : fill_x;
  assign m_hit   = l_hit | a_hit;
  assign m_data  = l_hit ? l_data : a_data;

  tlb_micro #(.N(UT_N)) i_micro (
    .clk(clk), .rst(rst), .lk_vpn(lk_va[31:12]), .lk_ns(lk_ns),
    .wr_en(u_wr), .wr_data(u_wdata), .inv_all(inv_all),
    .inv_addr(inv_addr_valid), .inv_vpn(inv_vpn),
    .hit(u_hit), .hit_data(u_data)
  );

  tlb_lock #(.N(LOCK_N)) i_lock (
    .clk(clk), .rst(rst), .lk_vpn(lk_va[31:12]), .lk_ns(lk_ns),
    .wr_en(to_lock), .wr_data(fill_x), .inv_all(inv_all), .unlock_all(unlock_all),
    .inv_addr(inv_addr_valid), .inv_vpn(inv_vpn),
    .hit(l_hit), .hit_data(l_data), .full(l_full)
  );

  tlb_main_array #(.SETS(MAIN_SETS)) i_array (
    .clk(clk), .rst(rst), .lk_en(lk_go && !u_hit), .lk_vpn(lk_va[31:12]), .lk_ns(lk_ns),
    .wr_en(to_arr), .wr_data(fill_x), .inv_all(inv_all),
    .inv_addr(inv_addr_valid), .inv_vpn(inv_vpn),
    .hit(a_hit), .hit_data(a_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_size  <= '0;
      pend_q    <= 1'b0;
      pend_x    <= '0;
      pend_va   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      pend_q    <= 1'b0;
      if (pend_q) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_pa    <= xlat_pa(pend_x, pend_va);
        rsp_size  <= pend_x.size;
      end else if (lk_valid) begin
        if (u_hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_pa    <= xlat_pa(u_data, lk_va);
          rsp_size  <= u_data.size;
        end else if (m_hit) begin
          pend_q  <= 1'b1;
          pend_x  <= m_data;
          pend_va <= lk_va;
        end else begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_pa    <= '0;
          rsp_size  <= '0;
        end
      end
    end
  end

  AST_FIRST_LEVEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lk_go && u_hit |=> rsp_valid && rsp_hit); // R1
  AST_SECOND_LEVEL_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    lk_go && !u_hit && m_hit |=> !rsp_valid ##1 (rsp_valid && rsp_hit)); // R2
  AST_DOUBLE_MISS_FLAG: assert property (@(posedge clk) disable iff (rst)
    lk_go && !u_hit && !m_hit |=> rsp_valid && !rsp_hit && rsp_pa == '0); // R3
  AST_SIZE_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit |-> rsp_size != 2'd3); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !rsp_valid); // R12

endmodule

// File: tb/test_tlb_two_level.sv
module test_tlb_two_level;
  localparam int UT_N = 32;
  localparam int SETS = 32;
  localparam int NM   = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_ns = 0;
  logic [31:0] lk_va = '0;
  logic        fill_valid = 0, fill_ns = 0, fill_lock = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0, inv_vpn = '0;
  logic [1:0]  fill_size = '0;
  logic        inv_all = 0, unlock_all = 0, inv_addr_valid = 0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_size;

  always #5 clk = ~clk;

  tlb_two_level #(.UT_N(UT_N), .MAIN_SETS(SETS), .LOCK_N(4)) i_tlb_two_level (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_ns(lk_ns),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_ns(fill_ns),
    .fill_size(fill_size), .fill_lock(fill_lock), .inv_all(inv_all), .unlock_all(unlock_all),
    .inv_addr_valid(inv_addr_valid), .inv_vpn(inv_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_size(rsp_size)
  );

  int n_chk = 0, n_bad = 0;
  bit busy = 1'b0;

  // reference model: one record per translation written
  logic [31:0] m_va [NM];
  logic [31:0] m_pa [NM];
  bit          m_ns [NM];
  logic [1:0]  m_sz [NM];
  int          m_home [NM];   // 0 first level only, 1 set array, 2 pinned
  bit          m_live [NM];
  bit          m_inu [NM];
  int          nm, uptr, lock_cnt;
  int          uslot [UT_N];
  int          s_mru [SETS];
  int          s_lru [SETS];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int shf(input logic [1:0] sz);
    return (sz == 2'd0) ? 12 : (sz == 2'd1) ? 20 : 24;
  endfunction

  function automatic bit covers(input int i, input logic [31:0] va);
    return (va >> shf(m_sz[i])) == (m_va[i] >> shf(m_sz[i]));
  endfunction

  function automatic int find(input logic [31:0] va, input bit ns);
    for (int i = 0; i < nm; i++)
      if (m_live[i] && m_ns[i] == ns && covers(i, va)) return i;
    return -1;
  endfunction

  function automatic void model_reset();
    nm = 0; uptr = 0; lock_cnt = 0;
    for (int i = 0; i < UT_N; i++) uslot[i] = -1;
    for (int s = 0; s < SETS; s++) begin s_mru[s] = -1; s_lru[s] = -1; end
  endfunction

  function automatic void drop_set(input int i);
    for (int s = 0; s < SETS; s++) begin
      if (s_mru[s] == i) s_mru[s] = -1;
      if (s_lru[s] == i) s_lru[s] = -1;
    end
  endfunction

  function automatic void kill(input int i);
    if (m_home[i] == 2) lock_cnt--;
    m_live[i] = 0; m_inu[i] = 0;
    drop_set(i);
    for (int k = 0; k < UT_N; k++) if (uslot[k] == i) uslot[k] = -1;
  endfunction

  function automatic void ring_write(input int i);
    int old;
    old = uslot[uptr];
    if (old >= 0) begin
      m_inu[old] = 0;
      if (m_home[old] == 0) kill(old);
    end
    uslot[uptr] = i; m_inu[i] = 1;
    uptr = (uptr + 1) % UT_N;
  endfunction

  function automatic void arr_insert(input int i);
    int s, ev;
    s = (m_va[i] >> 12) % SETS;
    if (s_mru[s] >= 0 && s_lru[s] >= 0) begin
      ev = s_lru[s];
      s_lru[s] = -1;
      if (m_inu[ev]) m_home[ev] = 0;   // survives only as a first-level copy
      else kill(ev);
    end
    if (s_mru[s] >= 0) s_lru[s] = s_mru[s];
    s_mru[s] = i;
  endfunction

  function automatic void arr_touch(input int i);
    int s;
    s = (m_va[i] >> 12) % SETS;
    if (s_lru[s] == i) begin s_lru[s] = s_mru[s]; s_mru[s] = i; end
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input bit ns,
                      input logic [1:0] sz, input bit lock);
    int i;
    fill_valid = 1; fill_vpn = va[31:12]; fill_pfn = pa[31:12];
    fill_ns = ns; fill_size = sz; fill_lock = lock;
    @(negedge clk);
    fill_valid = 0; fill_lock = 0;
    i = nm; nm++;
    m_va[i] = va; m_pa[i] = pa; m_ns[i] = ns; m_sz[i] = sz; m_live[i] = 1; m_inu[i] = 0;
    if (lock && lock_cnt < 4) begin m_home[i] = 2; lock_cnt++; end
    else if (sz == 2'd0) begin m_home[i] = 1; arr_insert(i); end
    else begin m_home[i] = 0; ring_write(i); end
  endtask

  task automatic lookup(input logic [31:0] va, input bit ns, input string req);
    int idx, lat;
    logic [31:0] epa, msk;
    idx = find(va, ns);
    lat = (idx >= 0 && !m_inu[idx]) ? 2 : 1;
    epa = 32'd0;
    if (idx >= 0) begin
      msk = 32'hFFFF_FFFF << shf(m_sz[idx]);
      epa = (m_pa[idx] & msk) | (va & ~msk);
    end
    busy = 1;
    lk_va = va; lk_ns = ns; lk_valid = 1;
    @(negedge clk);
    lk_valid = 0;
    if (lat == 2) begin
      check(rsp_valid == 1'b0, req, "response one cycle too early", {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
    end
    check(rsp_valid == 1'b1, req, "response strobe", {31'd0, rsp_valid}, 32'd1);
    check(rsp_hit == (idx >= 0), req, "hit flag", {31'd0, rsp_hit}, {31'd0, idx >= 0});
    check(rsp_pa == epa, req, "physical address", rsp_pa, epa);
    if (idx >= 0)
      check(rsp_size == m_sz[idx], req, "size code", {30'd0, rsp_size}, {30'd0, m_sz[idx]});
    if (idx >= 0 && lat == 2) begin
      if (m_home[idx] == 1) arr_touch(idx);
      ring_write(idx);
    end
    @(negedge clk);
    busy = 0;
  endtask

  task automatic flush(input bit unl);
    inv_all = 1; unlock_all = unl;
    @(negedge clk);
    inv_all = 0; unlock_all = 0;
    for (int i = 0; i < nm; i++) begin
      if (m_live[i]) begin
        if (m_home[i] == 2 && !unl) m_inu[i] = 0;
        else kill(i);
      end
    end
    for (int k = 0; k < UT_N; k++) uslot[k] = -1;
  endtask

  task automatic inv_at(input logic [31:0] va);
    inv_addr_valid = 1; inv_vpn = va[31:12];
    @(negedge clk);
    inv_addr_valid = 0;
    for (int i = 0; i < nm; i++) if (m_live[i] && covers(i, va)) kill(i);
  endtask

  // R3: no response without a request, checked every cycle
  always @(negedge clk) begin
    if (!busy && !rst) check(rsp_valid == 1'b0, "R3", "unrequested response", {31'd0, rsp_valid}, 32'd0);
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0, "R12", "valid during reset", {31'd0, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    lookup(32'h0040_3123, 0, "R12");

    // 4 KB page in the set array, then from the first level
    fill(32'h0040_3000, 32'h8123_4000, 0, 2'd0, 0);
    lookup(32'h0040_3ABC, 0, "R2");
    lookup(32'h0040_3004, 0, "R1");
    lookup(32'h0040_4000, 0, "R3");

    // security state
    lookup(32'h0040_3ABC, 1, "R5");
    fill(32'h0040_3000, 32'h5555_5000, 1, 2'd0, 0);
    lookup(32'h0040_3010, 1, "R5");
    lookup(32'h0040_3020, 0, "R5");

    // large pages
    fill(32'h1230_0000, 32'h4560_0000, 0, 2'd1, 0);
    lookup(32'h123A_BCDE, 0, "R7");
    lookup(32'h1230_0000, 0, "R4");
    lookup(32'h1240_0000, 0, "R4");
    fill(32'h2A00_0000, 32'h7C00_0000, 1, 2'd2, 0);
    lookup(32'h2AFF_FFF0, 1, "R4");
    lookup(32'h2A12_3456, 0, "R5");

    // set conflicts: three pages in set 5
    fill(32'h0000_5000, 32'h0100_0000, 0, 2'd0, 0);
    fill(32'h0002_5000, 32'h0200_0000, 0, 2'd0, 0);
    fill(32'h0004_5000, 32'h0300_0000, 0, 2'd0, 0);
    lookup(32'h0000_5008, 0, "R6");
    lookup(32'h0002_5008, 0, "R6");
    lookup(32'h0004_5008, 0, "R6");
    fill(32'h0006_5000, 32'h0400_0000, 0, 2'd0, 0);
    lookup(32'h0006_5000, 0, "R6");

    // pinned slots under pressure in set 9
    for (int k = 0; k < 4; k++) fill(32'h0000_9000 + k * 32'h20000, 32'hA000_0000 + k * 32'h1000, 0, 2'd0, 1);
    for (int k = 4; k < 7; k++) fill(32'h0000_9000 + k * 32'h20000, 32'hA000_0000 + k * 32'h1000, 0, 2'd0, 0);
    fill(32'h0000_9000 + 7 * 32'h20000, 32'hA000_7000, 0, 2'd0, 1);
    for (int k = 0; k < 8; k++) lookup(32'h0000_9044 + k * 32'h20000, 0, "R8");

    // invalidate all, keeping then dropping the pinned slots
    flush(0);
    lookup(32'h0000_9044, 0, "R9");
    lookup(32'h0006_9044, 0, "R9");
    lookup(32'h0040_3ABC, 0, "R9");
    lookup(32'h123A_BCDE, 0, "R9");
    lookup(32'h000E_9044, 0, "R9");
    flush(1);
    lookup(32'h0000_9044, 0, "R9");
    lookup(32'h0002_9044, 0, "R9");

    // invalidate by address across both levels and both security states
    fill(32'h0060_7000, 32'h1111_1000, 0, 2'd0, 0);
    fill(32'h0060_7000, 32'h2222_2000, 1, 2'd0, 0);
    fill(32'h0070_0000, 32'h3330_0000, 0, 2'd1, 0);
    lookup(32'h0060_7100, 0, "R10");
    lookup(32'h0071_2345, 0, "R10");
    inv_at(32'h0060_7ABC);
    lookup(32'h0060_7100, 0, "R10");
    lookup(32'h0060_7100, 1, "R10");
    lookup(32'h0071_2345, 0, "R10");
    inv_at(32'h0071_2000);
    lookup(32'h0070_0040, 0, "R10");

    // round-robin replacement in the first level
    do_reset();
    for (int k = 0; k <= UT_N; k++) fill(32'h4000_0000 + (k << 20), 32'h9000_0000 + (k << 20), 0, 2'd1, 0);
    lookup(32'h4000_0010, 0, "R11");
    lookup(32'h4010_0010, 0, "R11");
    lookup(32'h4000_0010 + (UT_N << 20), 0, "R11");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule